// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Access Checks

This block sits beside a pipeline's memory stage and keeps recently used page translations. Each lookup presents a 32-bit virtual address and an access kind (read or write). The upper bits of the address form the virtual page number, which is compared with every stored tag at once. On a match the physical address is formed in the same cycle. It is built from the stored physical page number and the 12-bit page offset, which passes through unchanged. When no entry matches, a miss flag tells an external walker to fetch the translation and load it through the refill port.

Every entry carries its own read, write and dirty flags. An access that the entry does not allow raises a fault alongside the hit, and the stored state stays as it was. A permitted write marks its entry dirty. New translations replace entries in first-in first-out order. A refill whose page is already stored updates that entry in place. A flush input drops every translation in a single cycle.

Top module: `tlb_fa`

## Requirements
- R1: With `lk_valid` high and a valid entry whose tag equals `lk_va[31:12]`, `lk_hit` rises in the same cycle and `lk_pa` equals that entry's 18-bit page number above `lk_va[11:0]` (tag 0xABCD1 with page 0x305BC maps 0xABCD1234 to 0x305BC234).
- R2: With `lk_valid` high and no matching valid entry, `lk_miss` is high and `lk_hit` is low. With `lk_valid` low, `lk_hit`, `lk_miss` and `lk_fault` are all low.
- R3: A write lookup (`lk_write`=1) that hits an entry with its write flag clear raises `lk_fault` in the same cycle and leaves the entry's dirty flag clear.
- R4: A read lookup (`lk_write`=0) that hits an entry with its read flag clear raises `lk_fault` in the same cycle.
- R5: A write lookup that hits a writable entry sets that entry's dirty flag at the next clock edge. `lk_dirty` shows the dirty flag of the hit entry.
- R6: A refill of a page not yet stored writes the slot under a victim pointer, which starts at slot 0 after reset and advances by one modulo the entry count. Once all slots are full, the oldest translation is the one replaced.
- R7: A refill of a page that is already stored overwrites that entry's page number and flags, and leaves the victim pointer where it was.
- R8: `flush` clears every valid flag at the next clock edge. A refill offered in the same cycle as a flush is discarded.
- R9: After reset no entry is valid, so every lookup misses.
- R10: A refill becomes visible to lookups from the cycle after it is accepted. A lookup made in the same cycle still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address of the lookup |
| lk_write | input | 1 | Access kind: 1 write, 0 read |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | No translation, walk needed |
| lk_fault | output | 1 | Access not permitted by the hit entry |
| lk_dirty | output | 1 | Dirty flag of the hit entry |
| lk_pa | output | 30 | Translated physical address |
| rf_valid | input | 1 | Refill request |
| rf_vpn | input | 20 | Virtual page number to load |
| rf_ppn | input | 18 | Physical page number to load |
| rf_rd | input | 1 | Read permission of the new entry |
| rf_wr | input | 1 | Write permission of the new entry |
| rf_dirty | input | 1 | Initial dirty flag of the new entry |

## Verification
The bench uses the default parameters: 32 entries, 32-bit virtual and 30-bit physical addresses, 4 KB pages. With 32 slots, every entry can be filled and the victim pointer wrapped in a few hundred cycles. The oldest-first eviction and the in-place update of a stored page can then be seen through ordinary lookups. The 30-bit physical width lets the translation of 0xABCD1234 to 0x305BC234 be checked exactly.

// File: rtl/tlb_fa_pkg.sv
`timescale 1ns/1ps
package tlb_fa_pkg;
   typedef struct packed {
      logic rd;
      logic wr;
      logic dirty;
   } tlb_perm_t;

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/tlb_fa_array.sv
`timescale 1ns/1ps
module tlb_fa_array
   import tlb_fa_pkg::*;
#(
   parameter int N     = 32,
   parameter int VPN_W = 20,
   parameter int PPN_W = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic [N-1:0]     lk_match,
   output logic [PPN_W-1:0] lk_ppn,
   output tlb_perm_t        lk_perm,
   input  logic [VPN_W-1:0] rf_vpn,
   output logic [N-1:0]     rf_match,
   input  logic [N-1:0]     wr_vec,
   input  logic [PPN_W-1:0] wr_ppn,
   input  tlb_perm_t        wr_perm,
   input  logic [N-1:0]     dset_vec
);
   logic [PPN_W-1:0] ppn_q  [N];
   tlb_perm_t        perm_q [N];

   for (genvar i = 0; i < N; i++) begin : g_ent
      logic             v_q;
      logic [VPN_W-1:0] tag_q;
      logic [PPN_W-1:0] pg_q;
      tlb_perm_t        pm_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q   <= 1'b0;
            tag_q <= '0;
            pg_q  <= '0;
            pm_q  <= '0;
         end else if (flush) begin
            v_q <= 1'b0;
         end else if (wr_vec[i]) begin
            v_q   <= 1'b1;
            tag_q <= rf_vpn;
            pg_q  <= wr_ppn;
            pm_q  <= wr_perm;
         end else if (dset_vec[i]) begin
            pm_q.dirty <= 1'b1;
         end
      end

      assign lk_match[i] = v_q && (tag_q == lk_vpn);
      assign rf_match[i] = v_q && (tag_q == rf_vpn);
      assign ppn_q[i]    = pg_q;
      assign perm_q[i]   = pm_q;
   end

   always_comb begin
      lk_ppn  = '0;
      lk_perm = '0;
      for (int i = 0; i < N; i++) begin
         if (lk_match[i]) begin
            lk_ppn  = lk_ppn | ppn_q[i];
            lk_perm = tlb_perm_t'(lk_perm | perm_q[i]);
         end
      end
   end
endmodule

// File: rtl/tlb_fa_victim.sv
`timescale 1ns/1ps
module tlb_fa_victim
   import tlb_fa_pkg::*;
#(
   parameter int N     = 32,
   parameter int IDX_W = $clog2(N)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   output logic [N-1:0] slot_vec
);
   logic [IDX_W-1:0] ptr_q;
   logic [IDX_W-1:0] ptr_nx;

   if (is_pow2(N)) begin : g_wrap_free
      assign ptr_nx = ptr_q + 1'b1;
   end else begin : g_wrap_cmp
      assign ptr_nx = (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   ptr_q <= '0;
      else if (adv) ptr_q <= ptr_nx;
   end

   for (genvar i = 0; i < N; i++) begin : g_dec
      assign slot_vec[i] = (ptr_q == IDX_W'(i));
   end
endmodule

// File: rtl/tlb_fa.sv
`timescale 1ns/1ps
module tlb_fa
   import tlb_fa_pkg::*;
#(
   parameter int ENTRIES = 32,
   parameter int VA_W    = 32,
   parameter int PA_W    = 30,
   parameter int OFF_W   = 12,
   localparam int VPN_W  = VA_W - OFF_W,
   localparam int PPN_W  = PA_W - OFF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             lk_valid,
   input  logic [VA_W-1:0]  lk_va,
   input  logic             lk_write,
   output logic             lk_hit,
   output logic             lk_miss,
   output logic             lk_fault,
   output logic             lk_dirty,
   output logic [PA_W-1:0]  lk_pa,
   input  logic             rf_valid,
   input  logic [VPN_W-1:0] rf_vpn,
   input  logic [PPN_W-1:0] rf_ppn,
   input  logic             rf_rd,
   input  logic             rf_wr,
   input  logic             rf_dirty
);
   if (ENTRIES < 32 || ENTRIES > 128) begin : g_bad_entries
      $error("tlb_fa: ENTRIES must lie in 32..128");
   end
   if (OFF_W < 1 || VPN_W < 1 || PPN_W < 1) begin : g_bad_widths
      $error("tlb_fa: address widths must exceed the page offset");
   end

   logic [ENTRIES-1:0] lk_match, rf_match, slot_vec, wr_vec, dset_vec;
   logic [PPN_W-1:0]   hit_ppn;
   tlb_perm_t          hit_perm;
   tlb_perm_t          new_perm;
   logic               take_rf, rf_dup, perm_ok;

   assign new_perm = '{rd: rf_rd, wr: rf_wr, dirty: rf_dirty};
   assign take_rf  = rf_valid && !flush;
   assign rf_dup   = |rf_match;
   assign wr_vec   = !take_rf ? '0 : (rf_dup ? rf_match : slot_vec);

   assign lk_hit   = lk_valid && (|lk_match);
   assign lk_miss  = lk_valid && !(|lk_match);
   assign perm_ok  = lk_write ? hit_perm.wr : hit_perm.rd;
   assign lk_fault = lk_hit && !perm_ok;
   assign lk_dirty = lk_hit && hit_perm.dirty;
   assign lk_pa    = {hit_ppn, lk_va[OFF_W-1:0]};
   assign dset_vec = lk_match & {ENTRIES{lk_valid && lk_write && hit_perm.wr}};

   tlb_fa_array #(.N(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .lk_vpn   (lk_va[VA_W-1:OFF_W]),
      .lk_match (lk_match),
      .lk_ppn   (hit_ppn),
      .lk_perm  (hit_perm),
      .rf_vpn   (rf_vpn),
      .rf_match (rf_match),
      .wr_vec   (wr_vec),
      .wr_ppn   (rf_ppn),
      .wr_perm  (new_perm),
      .dset_vec (dset_vec)
   );

   tlb_fa_victim #(.N(ENTRIES)) u_victim (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (take_rf && !rf_dup),
      .slot_vec (slot_vec)
   );
endmodule

// File: rtl/tlb_fa_chk.sv
`timescale 1ns/1ps
module tlb_fa_chk #(
   parameter int VA_W  = 32,
   parameter int PA_W  = 30,
   parameter int OFF_W = 12,
   localparam int VPN_W = VA_W - OFF_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush,
   input logic             lk_valid,
   input logic [VA_W-1:0]  lk_va,
   input logic             lk_hit,
   input logic             lk_miss,
   input logic             lk_fault,
   input logic [PA_W-1:0]  lk_pa,
   input logic             rf_valid,
   input logic [VPN_W-1:0] rf_vpn
);
   a_r2_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> (lk_hit != lk_miss));

   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> (!lk_hit && !lk_miss && !lk_fault));

   a_r1_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_pa[OFF_W-1:0] == lk_va[OFF_W-1:0]));

   a_r3_fault_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      lk_fault |-> lk_hit);

   a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !lk_hit);

   a_r10_refill_seen: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_valid && !flush) |=>
         (!lk_valid || (lk_va[VA_W-1:OFF_W] != $past(rf_vpn)) || lk_hit));
endmodule

bind tlb_fa tlb_fa_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .flush    (flush),
   .lk_valid (lk_valid),
   .lk_va    (lk_va),
   .lk_hit   (lk_hit),
   .lk_miss  (lk_miss),
   .lk_fault (lk_fault),
   .lk_pa    (lk_pa),
   .rf_valid (rf_valid),
   .rf_vpn   (rf_vpn)
);

// File: tb/tb_tlb_fa.sv
`timescale 1ns/1ps
module tb_tlb_fa;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_va = '0;
   logic        lk_write = 1'b0;
   logic        lk_hit, lk_miss, lk_fault, lk_dirty;
   logic [29:0] lk_pa;
   logic        rf_valid = 1'b0;
   logic [19:0] rf_vpn = '0;
   logic [17:0] rf_ppn = '0;
   logic        rf_rd = 1'b0, rf_wr = 1'b0, rf_dirty = 1'b0;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   tlb_fa dut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .lk_valid(lk_valid), .lk_va(lk_va), .lk_write(lk_write),
      .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
      .lk_dirty(lk_dirty), .lk_pa(lk_pa),
      .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn),
      .rf_rd(rf_rd), .rf_wr(rf_wr), .rf_dirty(rf_dirty)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic refill(input logic [19:0] vpn, input logic [17:0] ppn,
                         input bit rd, input bit wr, input bit dt);
      @(negedge clk);
      rf_valid = 1'b1; rf_vpn = vpn; rf_ppn = ppn;
      rf_rd = rd; rf_wr = wr; rf_dirty = dt;
      @(negedge clk);
      rf_valid = 1'b0;
   endtask

   // one lookup held across exactly one rising edge; outputs sampled before it
   task automatic look(input logic [31:0] va, input bit wr, input string req,
                       input bit e_hit, input logic [29:0] e_pa,
                       input bit e_fault, input bit e_dirty);
      @(negedge clk);
      lk_valid = 1'b1; lk_va = va; lk_write = wr;
      #2;
      chk(lk_hit == e_hit && lk_miss == !e_hit, req, {lk_hit, lk_miss}, {e_hit, !e_hit});
      if (e_hit) begin
         chk(lk_pa == e_pa, req, lk_pa, e_pa);
         chk(lk_fault == e_fault, req, lk_fault, e_fault);
         chk(lk_dirty == e_dirty, req, lk_dirty, e_dirty);
      end
      @(negedge clk);
      lk_valid = 1'b0; lk_write = 1'b0;
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
   endtask

   task automatic t_reset();
      look(32'hABCD1234, 1'b0, "R9 reset miss", 1'b0, '0, 1'b0, 1'b0);
      @(negedge clk);
      #2;
      chk(!lk_hit && !lk_miss && !lk_fault, "R2 idle quiet", {lk_hit, lk_miss, lk_fault}, 0);
   endtask

   task automatic t_translate();
      refill(20'hABCD1, 18'h305BC, 1'b1, 1'b1, 1'b0);
      look(32'hABCD1234, 1'b0, "R1 translate", 1'b1, 30'h305BC234, 1'b0, 1'b0);
      look(32'hABCD2234, 1'b0, "R2 miss neighbour", 1'b0, '0, 1'b0, 1'b0);
   endtask

   task automatic t_same_cycle();
      @(negedge clk);
      rf_valid = 1'b1; rf_vpn = 20'h00777; rf_ppn = 18'h00123;
      rf_rd = 1'b1; rf_wr = 1'b1; rf_dirty = 1'b0;
      lk_valid = 1'b1; lk_va = 32'h00777ABC; lk_write = 1'b0;
      #2;
      chk(lk_miss && !lk_hit, "R10 same cycle old", {lk_hit, lk_miss}, 2'b01);
      @(negedge clk);
      rf_valid = 1'b0;
      #2;
      chk(lk_hit && lk_pa == 30'h00123ABC, "R10 next cycle new", lk_pa, 30'h00123ABC);
      @(negedge clk);
      lk_valid = 1'b0;
   endtask

   task automatic t_dirty();
      look(32'hABCD1008, 1'b1, "R5 write clean", 1'b1, 30'h305BC008, 1'b0, 1'b0);
      look(32'hABCD1008, 1'b0, "R5 dirty set", 1'b1, 30'h305BC008, 1'b0, 1'b1);
   endtask

   task automatic t_protect();
      refill(20'h11111, 18'h2AAAA, 1'b1, 1'b0, 1'b0);
      look(32'h11111FF0, 1'b1, "R3 write fault", 1'b1, 30'h2AAAAFF0, 1'b1, 1'b0);
      look(32'h11111FF0, 1'b0, "R3 dirty kept clear", 1'b1, 30'h2AAAAFF0, 1'b0, 1'b0);
      refill(20'h22222, 18'h01234, 1'b0, 1'b1, 1'b0);
      look(32'h22222010, 1'b0, "R4 read fault", 1'b1, 30'h01234010, 1'b1, 1'b0);
   endtask

   task automatic t_fifo();
      do_flush();
      look(32'hABCD1234, 1'b0, "R8 flushed", 1'b0, '0, 1'b0, 1'b0);
      for (int k = 0; k < 32; k++)
         refill(20'h10000 + 20'(k), 18'h100 + 18'(k), 1'b1, 1'b1, 1'b0);
      look(32'h10000000, 1'b0, "R6 full first", 1'b1, 30'h00100000, 1'b0, 1'b0);
      look(32'h1001F000, 1'b0, "R6 full last", 1'b1, 30'h0011F000, 1'b0, 1'b0);
      refill(20'h20000, 18'h3F000, 1'b1, 1'b1, 1'b0);
      look(32'h10000000, 1'b0, "R6 oldest evicted", 1'b0, '0, 1'b0, 1'b0);
      look(32'h10001000, 1'b0, "R6 second kept", 1'b1, 30'h00101000, 1'b0, 1'b0);
      look(32'h20000000, 1'b0, "R6 new present", 1'b1, 30'h3F000000, 1'b0, 1'b0);
      refill(20'h10005, 18'h0BEEF, 1'b1, 1'b0, 1'b1);
      look(32'h10005004, 1'b0, "R7 overwrite", 1'b1, 30'h0BEEF004, 1'b0, 1'b1);
      refill(20'h20001, 18'h3F001, 1'b1, 1'b1, 1'b0);
      look(32'h10001000, 1'b0, "R7 pointer held evicts next", 1'b0, '0, 1'b0, 1'b0);
      look(32'h10002000, 1'b0, "R7 third kept", 1'b1, 30'h00102000, 1'b0, 1'b0);
      look(32'h10005000, 1'b0, "R7 updated kept", 1'b1, 30'h0BEEF000, 1'b0, 1'b1);
   endtask

   task automatic t_flush_wins();
      @(negedge clk);
      flush = 1'b1; rf_valid = 1'b1; rf_vpn = 20'h33333; rf_ppn = 18'h00333;
      rf_rd = 1'b1; rf_wr = 1'b1; rf_dirty = 1'b0;
      @(negedge clk);
      flush = 1'b0; rf_valid = 1'b0;
      look(32'h33333000, 1'b0, "R8 refill dropped", 1'b0, '0, 1'b0, 1'b0);
      look(32'h20000000, 1'b0, "R8 all cleared", 1'b0, '0, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_translate();
      t_same_cycle();
      t_dirty();
      t_protect();
      t_fifo();
      t_flush_wins();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule